// File: doc/BRIEF.md
# Multicycle Processor Sequencer with Shared ALU and Unified Memory

This block is a small multicycle processor core. One state machine steps each instruction through a short sequence of cycles. One ALU serves every arithmetic need, the PC increment included, and one word memory serves both instruction fetch and data access. An address select picks the memory address: the PC during fetch, the ALU output register during a data access. A branch-target holding register is loaded during decode, before the branch condition is known. The compare cycle that follows then either reloads the PC from that register or leaves it at PC+4.

The supported instructions are load word, store word, branch-if-equal, jump, and the R-type operations add, sub, and, or and slt. The opcode sits in bits 31:26: 0x00 is R-type, 0x23 load, 0x2B store, 0x04 branch-if-equal and 0x02 jump. R-type selects its function in bits 5:0: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A slt. Fields rs, rt and rd sit in bits 25:21, 20:16 and 15:11. The signed immediate sits in bits 15:0, and the jump word address in bits 25:0.

Memory is filled through a valid/ready load port. The port is ready only while the core is idle. A word transfers on a cycle where both valid and ready are high. When ready is low the source must hold the word and wait; a word offered at that time is never written. Execution starts when `run` is raised and stops at the next instruction boundary after `run` falls.

Top module: `mc_core`

## Requirements
- R1: After reset the PC is 0, the core is idle with `ld_ready` high, and no memory, PC or target strobe is active.
- R2: A load-port word is written only when `ld_valid` and `ld_ready` are both high. `ld_ready` is low from the cycle after `run` rises until the core is idle again, so a word offered in that time changes nothing.
- R3: Every instruction starts with one fetch cycle. In that cycle the address select is 0 (PC), memory is read, the instruction register is loaded, and the PC takes PC+4 from the shared ALU with PC source 0.
- R4: The cycle after each fetch is decode. There the target register takes PC+4 plus the sign-extended offset shifted left by 2, with the target strobe high, for every opcode.
- R5: Branch-if-equal takes 3 cycles. In its compare cycle, equal registers load the PC from the target register (PC source 1). Unequal registers leave the PC at the fetch address plus 4.
- R6: A load takes 5 cycles. It reads memory at rs plus the sign-extended immediate with the address select at 1, then writes the word to rt.
- R7: A store takes 4 cycles. It writes rt to memory at rs plus the sign-extended immediate, with the address select at 1.
- R8: An R-type instruction takes 4 cycles and writes rd with add, sub, and, or, or signed set-less-than of rs and rt.
- R9: A jump takes 3 cycles. It loads the PC with PC+4 bits 31:28, then the 26-bit field, then two zero bits (PC source 2), and it does not use the target register.
- R10: Register 0 always reads zero; writes to it are discarded.
- R11: An unrecognized opcode takes 2 cycles (fetch, decode) and writes no register or memory.
- R12: With `run` low, the core goes idle after the current instruction ends and fetches nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execute while high |
| ld_valid | input | 1 | Load-port word offered |
| ld_ready | output | 1 | Load port accepts (core idle) |
| ld_addr | input | AW | Load-port word address |
| ld_data | input | 32 | Load-port word |
| dbg_sel | input | 5 | Register number to observe |
| dbg_data | output | 32 | Value of the selected register |
| pc | output | 32 | Program counter |
| mem_addr | output | 32 | Byte address presented to memory |
| iord | output | 1 | Address select: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| pc_wr | output | 1 | PC write strobe |
| pc_src | output | 2 | PC source: 0 ALU, 1 target, 2 jump |
| tgt_wr | output | 1 | Target register write strobe |

## Verification
The bench checks the length of every instruction class by timing the gaps between fetch strobes. A sequencer that skips or repeats a state shifts every later fetch. The list of fetched PCs catches a taken branch that lands on PC+4, a not-taken branch that jumps, a jump routed through the target register, and a halt loop with a negative offset that lands beside itself. A write to register 0 and a load-port word offered while the core runs are both checked through later reads, so a design that lets either through shows a wrong register value. Dropping `run` must leave the core idle with the port ready again, and a design that keeps fetching is caught.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_ADDR, S_MRD, S_MWB,
    S_MWR, S_REXE, S_RWB, S_BEQ, S_JMP
  } state_t;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_t;

  typedef enum logic [1:0] {
    SB_REG, SB_FOUR, SB_IMM, SB_IMM4
  } srcb_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic       iord;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       pc_wr;
    logic [1:0] pc_src;
    logic       tgt_wr;
    logic       src_a;
    srcb_t      src_b;
    alu_op_t    alu_op;
    logic       ab_wr;
    logic       aout_wr;
    logic       mdr_wr;
    logic       rf_wr;
    logic       rf_dst_rd;
    logic       rf_from_mem;
  } ctl_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_t      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  input  logic [$clog2(NREG)-1:0] ra3,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2,
  output logic [W-1:0]            rd3,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd
);
  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   regs[i] <= '0;
      else if (we && wa == i[$clog2(NREG)-1:0]) regs[i] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];
endmodule

// File: rtl/mc_mem.sv
module mc_mem
  import mc_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int WORDS = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data
);
  logic [W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (ld_we)   store[ld_addr] <= ld_data;
    else if (we) store[addr]    <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       zero,
  output ctl_t       ctl,
  output logic       idle
);
  state_t st_q, st_d, done_st;

  assign done_st = run ? S_FETCH : S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:   if (run) st_d = S_FETCH;
      S_FETCH:  st_d = S_DECODE;
      S_DECODE: begin
        unique case (opcode)
          OP_LW, OP_SW: st_d = S_ADDR;
          OP_RTYPE:     st_d = S_REXE;
          OP_BEQ:       st_d = S_BEQ;
          OP_J:         st_d = S_JMP;
          default:      st_d = done_st;
        endcase
      end
      S_ADDR:   st_d = (opcode == OP_LW) ? S_MRD : S_MWR;
      S_MRD:    st_d = S_MWB;
      S_REXE:   st_d = S_RWB;
      default:  st_d = done_st;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.src_b  = SB_REG;
    ctl.alu_op = ALU_ADD;
    unique case (st_q)
      S_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_wr  = 1'b1;
        ctl.src_b  = SB_FOUR;
        ctl.pc_wr  = 1'b1;
      end
      S_DECODE: begin
        ctl.ab_wr  = 1'b1;
        ctl.src_b  = SB_IMM4;
        ctl.tgt_wr = 1'b1;
      end
      S_ADDR: begin
        ctl.src_a   = 1'b1;
        ctl.src_b   = SB_IMM;
        ctl.aout_wr = 1'b1;
      end
      S_MRD: begin
        ctl.iord   = 1'b1;
        ctl.mem_rd = 1'b1;
        ctl.mdr_wr = 1'b1;
      end
      S_MWB: begin
        ctl.rf_wr       = 1'b1;
        ctl.rf_from_mem = 1'b1;
      end
      S_MWR: begin
        ctl.iord   = 1'b1;
        ctl.mem_wr = 1'b1;
      end
      S_REXE: begin
        ctl.src_a   = 1'b1;
        ctl.aout_wr = 1'b1;
        unique case (funct)
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          default: ctl.alu_op = ALU_ADD;
        endcase
      end
      S_RWB: begin
        ctl.rf_wr     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      S_BEQ: begin
        ctl.src_a  = 1'b1;
        ctl.alu_op = ALU_SUB;
        ctl.pc_src = 2'd1;
        ctl.pc_wr  = zero;
      end
      S_JMP: begin
        ctl.pc_src = 2'd2;
        ctl.pc_wr  = 1'b1;
      end
      default: ;
    endcase
  end

  assign idle = (st_q == S_IDLE);
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  parameter int NREG      = 32,
  localparam int AW       = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [AW-1:0]     ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  input  logic [RIDX-1:0]   dbg_sel,
  output logic [XLEN-1:0]   dbg_data,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   mem_addr,
  output logic              iord,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              pc_wr,
  output logic [1:0]        pc_src,
  output logic              tgt_wr
);
  ctl_t            ctl;
  logic            idle;
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aout_q, mdr_q, tgt_q;
  logic [XLEN-1:0] alu_a, alu_b, alu_y, sext, mem_rdata, pc_d;
  logic [XLEN-1:0] rd1, rd2, rf_wd;
  logic [RIDX-1:0] rf_wa;
  logic            zero;

  mc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run),
    .opcode(ir_q[31:26]), .funct(ir_q[5:0]), .zero(zero),
    .ctl(ctl), .idle(idle)
  );

  assign sext = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};

  assign alu_a = ctl.src_a ? a_q : pc_q;
  always_comb begin
    unique case (ctl.src_b)
      SB_FOUR: alu_b = 32'd4;
      SB_IMM:  alu_b = sext;
      SB_IMM4: alu_b = {sext[XLEN-3:0], 2'b00};
      default: alu_b = b_q;
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .a(alu_a), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(zero)
  );

  assign mem_addr = ctl.iord ? aout_q : pc_q;

  mc_mem #(.W(XLEN), .WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .addr(mem_addr[AW+1:2]), .we(ctl.mem_wr), .wdata(b_q),
    .rdata(mem_rdata), .ld_we(ld_valid && ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data)
  );

  assign rf_wa = ctl.rf_dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = ctl.rf_from_mem ? mdr_q : aout_q;

  mc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(ir_q[25:21]), .ra2(ir_q[20:16]), .ra3(dbg_sel),
    .rd1(rd1), .rd2(rd2), .rd3(dbg_data),
    .we(ctl.rf_wr), .wa(rf_wa), .wd(rf_wd)
  );

  always_comb begin
    unique case (ctl.pc_src)
      2'd1:    pc_d = tgt_q;
      2'd2:    pc_d = {pc_q[31:28], ir_q[25:0], 2'b00};
      default: pc_d = alu_y;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      aout_q <= '0;
      mdr_q  <= '0;
      tgt_q  <= '0;
    end else begin
      if (ctl.pc_wr)   pc_q   <= pc_d;
      if (ctl.ir_wr)   ir_q   <= mem_rdata;
      if (ctl.ab_wr)   begin a_q <= rd1; b_q <= rd2; end
      if (ctl.aout_wr) aout_q <= alu_y;
      if (ctl.mdr_wr)  mdr_q  <= mem_rdata;
      if (ctl.tgt_wr)  tgt_q  <= alu_y;
    end
  end

  assign ld_ready = idle;
  assign pc       = pc_q;
  assign iord     = ctl.iord;
  assign mem_rd   = ctl.mem_rd;
  assign mem_wr   = ctl.mem_wr;
  assign pc_wr    = ctl.pc_wr;
  assign pc_src   = ctl.pc_src;
  assign tgt_wr   = ctl.tgt_wr;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_ready,
  input logic [4:0]  dbg_sel,
  input logic [31:0] dbg_data,
  input logic [31:0] pc,
  input logic        iord,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        pc_wr,
  input logic [1:0]  pc_src,
  input logic        tgt_wr,
  input logic [31:0] tgt
);
  logic fetch;
  assign fetch = mem_rd && !iord;

  p_fetch_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> pc == $past(pc) + 32'd4);

  p_decode_tgt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> tgt_wr);

  p_taken_from_tgt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'd1) |=> pc == $past(tgt));

  p_store_data_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> iord);

  p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> (!mem_rd && !mem_wr && !pc_wr && !tgt_wr));

  p_jump_no_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'd2) |-> !tgt_wr);

  p_zero_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_sel == 5'd0) |-> (dbg_data == 32'd0));
endmodule

bind mc_core mc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_ready(ld_ready),
  .dbg_sel(dbg_sel), .dbg_data(dbg_data), .pc(pc),
  .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .pc_wr(pc_wr), .pc_src(pc_src), .tgt_wr(tgt_wr), .tgt(tgt_q)
);

// File: tb/mc_core_test.sv
`timescale 1ns/1ps
module mc_core_test;
  localparam int AW = 6;
  localparam int NF = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic ld_valid = 1'b0;
  logic ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0] dbg_sel = '0;
  logic [31:0] dbg_data, pc, mem_addr;
  logic iord, mem_rd, mem_wr, pc_wr, tgt_wr;
  logic [1:0] pc_src;

  always #2.5 clk = ~clk;

  mc_core uut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data), .pc(pc), .mem_addr(mem_addr),
    .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_wr(pc_wr),
    .pc_src(pc_src), .tgt_wr(tgt_wr)
  );

  // expected {fetch pc, cycles until next fetch}: R3 R5 R6 R7 R8 R9 R11
  localparam logic [39:0] FETCH_TBL [NF] = '{
    {32'd0,  8'd5}, {32'd4,  8'd5}, {32'd8,  8'd4}, {32'd12, 8'd4},
    {32'd16, 8'd4}, {32'd20, 8'd4}, {32'd24, 8'd4}, {32'd28, 8'd4},
    {32'd32, 8'd5}, {32'd36, 8'd3}, {32'd40, 8'd3}, {32'd48, 8'd4},
    {32'd52, 8'd2}, {32'd56, 8'd3}, {32'd64, 8'd5}, {32'd68, 8'd3},
    {32'd68, 8'd0}
  };

  // expected {register, value}: R6 R7 R8 R10 R2
  localparam logic [36:0] REG_TBL [12] = '{
    {5'd0, 32'd0}, {5'd1, 32'd5}, {5'd2, 32'd7}, {5'd3, 32'd12},
    {5'd4, 32'hFFFF_FFFE}, {5'd5, 32'd5}, {5'd6, 32'd7}, {5'd7, 32'd1},
    {5'd8, 32'd12}, {5'd9, 32'd0}, {5'd10, 32'd0}, {5'd11, 32'd7}
  };

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int nfetch = 0;
  int fetch_cyc [NF];
  logic [31:0] fetch_pc [NF];
  int taken_n = 0, jump_n = 0, store_n = 0, tgt_bad = 0;
  logic prev_fetch = 1'b0;

  function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ld_word(input int a, input logic [31:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a[AW-1:0]; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mem_rd && !iord) begin
      if (nfetch < NF) begin
        fetch_cyc[nfetch] = cyc;
        fetch_pc[nfetch] = pc;
      end
      nfetch++;
    end
    if (nfetch < NF) begin
      if (pc_wr && pc_src == 2'd1) taken_n++;
      if (pc_wr && pc_src == 2'd2) jump_n++;
      if (mem_wr) store_n++;
      if (tgt_wr !== prev_fetch) tgt_bad++;
    end
    prev_fetch = mem_rd && !iord;
  end

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pc", pc, 32'd0);
    check("R1 ready", {31'd0, ld_ready}, 32'd1);
    check("R1 strobes", {26'd0, mem_rd, mem_wr, pc_wr, tgt_wr, pc_src}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    ld_word(0,  enc_i(6'h23, 0, 1, 160));
    ld_word(1,  enc_i(6'h23, 0, 2, 164));
    ld_word(2,  enc_r(1, 2, 3, 6'h20));
    ld_word(3,  enc_r(1, 2, 4, 6'h22));
    ld_word(4,  enc_r(1, 2, 5, 6'h24));
    ld_word(5,  enc_r(1, 2, 6, 6'h25));
    ld_word(6,  enc_r(1, 2, 7, 6'h2A));
    ld_word(7,  enc_i(6'h2B, 0, 3, 168));
    ld_word(8,  enc_i(6'h23, 0, 8, 168));
    ld_word(9,  enc_i(6'h04, 1, 2, 5));
    ld_word(10, enc_i(6'h04, 5, 1, 1));
    ld_word(11, enc_r(1, 1, 9, 6'h20));
    ld_word(12, enc_r(1, 1, 0, 6'h20));
    ld_word(13, {6'h3F, 26'd0});
    ld_word(14, {6'h02, 26'd16});
    ld_word(15, enc_r(1, 1, 10, 6'h20));
    ld_word(16, enc_i(6'h23, 3, 11, 152));
    ld_word(17, enc_i(6'h04, 0, 0, -1));
    ld_word(40, 32'd5);
    ld_word(41, 32'd7);
    ld_word(42, 32'd0);

    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    // R2: word offered while running must not land (address 41 is read later)
    ld_valid = 1'b1; ld_addr = 6'd41; ld_data = 32'd99;
    #1 check("R2 ready low while running", {31'd0, ld_ready}, 32'd0);
    repeat (3) @(negedge clk);
    ld_valid = 1'b0;

    while (nfetch < NF) @(negedge clk);
    run = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    // R12: idle after the last instruction ends, no more fetches
    check("R12 idle ready", {31'd0, ld_ready}, 32'd1);
    check("R12 fetch count", nfetch, NF);

    // R3 R5 R9 R11 R6 R7 R8: fetch order and per-instruction cycle counts
    for (int k = 0; k < NF; k++) begin
      check($sformatf("R3/R5/R9 fetch pc #%0d", k), fetch_pc[k], FETCH_TBL[k][39:8]);
      if (k < NF - 1)
        check($sformatf("R6/R7/R8/R11 gap #%0d", k),
              fetch_cyc[k+1] - fetch_cyc[k], {24'd0, FETCH_TBL[k][7:0]});
    end
    check("R5 taken count", taken_n, 2);
    check("R9 jump count", jump_n, 1);
    check("R7 store count", store_n, 1);
    check("R4 target strobe only after fetch", tgt_bad, 0);

    // R6 R7 R8 R10 R2: register results
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      dbg_sel = REG_TBL[k][36:32];
      #1 check($sformatf("R8/R10 reg r%0d", k), dbg_data, REG_TBL[k][31:0]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule